// File: doc/BRIEF.md
# USB OUT Endpoint Receive Controller

This block is the receive-side handshake logic for a single USB OUT endpoint. It takes events that a packet decoder upstream has already produced: an OUT token for this endpoint, and the end of the data packet that follows. With the end-of-packet event come the data PID (DATA0 or DATA1), the byte count and an error indication that covers CRC and bit-stuff faults. The block compares the byte count with the free space the FIFO reports. Together with the software control bits, this gives a single verdict for each packet: accept it, drop it, or answer it with ACK, NAK or STALL.

The verdict appears one clock after the end-of-packet event. It is a handshake strobe with a code, plus a commit strobe or a drop strobe that tells the FIFO whether to keep the bytes it has just buffered. The block tracks the expected data toggle and keeps a packet-ready flag. It also keeps sticky flags for overrun, data error and sent stall, and it latches the byte count of the last accepted packet. Software clears packet-ready itself. In auto-clear mode, packet-ready also clears when the reader reports that it has drained the packet.

Top module: `usb_out_ep_rx`

## Requirements
- R1: During and after a synchronous active-low reset, every strobe, flag, the expected toggle and the byte count are 0.
- R2: An end-of-packet event counts only if an OUT token arrived after the last counted event. Without such a token it produces no handshake, no commit and no drop, and the byte count is unchanged.
- R3: A packet that is clean and fits, with a PID that matches the expected toggle, is accepted in a non-isochronous mode. One cycle after the event this gives a handshake with code ACK (2'b01), a commit strobe, packet-ready set, the byte count latched (0 included) and the expected toggle inverted. PID input 1 means DATA1.
- R4: A clean packet that fits but carries the PID opposite to the expected toggle gets an ACK and a drop strobe. The toggle, the byte count and packet-ready do not change.
- R5: A packet whose byte count exceeds the free space gets a drop strobe and sets the sticky overrun flag. In non-isochronous mode it is answered with NAK (2'b10). A packet that exactly fills the free space is accepted.
- R6: A packet with the error input set gets no handshake and a drop strobe, and sets the sticky data-error flag. The toggle, packet-ready and the byte count are unchanged. This rule takes priority over stall.
- R7: While send-stall is high in non-isochronous mode, a clean packet is answered with STALL (2'b11) and dropped, and the sticky sent-stall flag is set.
- R8: In isochronous mode no handshake is ever produced, send-stall is ignored, and the PID is neither checked nor used to advance the toggle. A clean packet that fits is committed.
- R9: A clear-toggle pulse sets the expected toggle to 0. It wins over an advance in the same cycle.
- R10: Packet-ready clears on a software clear pulse. The drained indication clears it only when auto-clear is enabled, and is ignored otherwise. A new commit wins over either clear.
- R11: The flag-clear vector clears the sticky flags: bit 0 overrun, bit 1 data error, bit 2 sent stall. A hardware set in the same cycle wins.
- R12: The full output is high exactly when the free space is below the parameter MAX_PKT (default 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tok_out | input | 1 | OUT token addressed to this endpoint (pulse) |
| pkt_end | input | 1 | End of received data packet (pulse) |
| pkt_pid1 | input | 1 | Data PID of the packet: 1 DATA1, 0 DATA0 |
| pkt_len | input | 10 | Byte count of the packet |
| pkt_err | input | 1 | CRC or bit-stuff error seen in the packet |
| fifo_free | input | 10 | Free FIFO space in bytes |
| cfg_iso | input | 1 | Isochronous mode |
| cfg_auto_clr | input | 1 | Allow the drained indication to clear packet-ready |
| sw_stall | input | 1 | Send-stall control (level) |
| tog_clr | input | 1 | Reset the expected toggle to DATA0 (pulse) |
| rdy_clr | input | 1 | Software clear of packet-ready (pulse) |
| flag_clr | input | 3 | Sticky flag clears: bit0 overrun, bit1 data error, bit2 sent stall |
| rd_done | input | 1 | Reader has drained the current packet (pulse) |
| hs_valid | output | 1 | Handshake to send (one-cycle strobe) |
| hs_code | output | 2 | Handshake: 01 ACK, 10 NAK, 11 STALL, 00 none |
| pkt_commit | output | 1 | FIFO keeps the packet (strobe) |
| pkt_drop | output | 1 | FIFO discards the packet (strobe) |
| pkt_ready | output | 1 | A received packet awaits software |
| rx_count | output | 10 | Byte count of the last accepted packet |
| exp_toggle | output | 1 | Expected data toggle of the next packet |
| fifo_full | output | 1 | FIFO lacks room for a maximum-size packet |
| overrun | output | 1 | Sticky: a packet was dropped for lack of space |
| data_err | output | 1 | Sticky: a packet arrived with CRC or bit-stuff error |
| sent_stall | output | 1 | Sticky: a STALL was answered |

## Verification
The assertions take for granted that the decoder gives at most one end-of-packet event per OUT token. They also assume the PID, length, error, free-space and mode inputs are stable in the cycle of that event, and that the control pulses last a single cycle. The stimulus drives every packet as a token in one cycle and an end-of-packet event in the next, with all of its fields set at the same time. Mode and stall inputs change only between packets. The only deliberate collisions are a clear pulse that lands in the cycle of an end-of-packet event, which the set-wins and clear-wins rules cover.

// File: rtl/usb_out_ep_pkg.sv
// Package: shared handshake encoding and sticky flag indices for the
// OUT endpoint receive controller.
package usb_out_ep_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_e;

    localparam int FLAG_OVR = 0;
    localparam int FLAG_ERR = 1;
    localparam int FLAG_STL = 2;
    localparam int FLAG_N   = 3;
endpackage

// File: rtl/out_ep_decide.sv
// Module: out_ep_decide
// Purely combinational verdict for one counted end-of-packet event.
// Priority: error, stall (non-iso), lack of space, iso accept, toggle
// mismatch, accept. Assumes all packet fields are valid while evt is high.
module out_ep_decide
    import usb_out_ep_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             evt,
    input  logic             pid1,
    input  logic [CNT_W-1:0] len,
    input  logic [CNT_W-1:0] free,
    input  logic             crc_err,
    input  logic             stall,
    input  logic             iso,
    input  logic             tog_exp,
    output logic             hs_en,
    output hs_code_e         hs_code,
    output logic             commit,
    output logic             drop,
    output logic [FLAG_N-1:0] flag_set,
    output logic             tog_adv
);
    // Verdict selection by fixed priority.
    always_comb begin
        hs_en    = 1'b0;
        hs_code  = HS_NONE;
        commit   = 1'b0;
        drop     = 1'b0;
        flag_set = '0;
        tog_adv  = 1'b0;
        if (evt) begin
            if (crc_err) begin
                drop               = 1'b1;
                flag_set[FLAG_ERR] = 1'b1;
            end else if (stall && !iso) begin
                hs_en              = 1'b1;
                hs_code            = HS_STALL;
                drop               = 1'b1;
                flag_set[FLAG_STL] = 1'b1;
            end else if (len > free) begin
                drop               = 1'b1;
                flag_set[FLAG_OVR] = 1'b1;
                if (!iso) begin
                    hs_en   = 1'b1;
                    hs_code = HS_NAK;
                end
            end else if (iso) begin
                commit = 1'b1;
            end else if (pid1 != tog_exp) begin
                hs_en   = 1'b1;
                hs_code = HS_ACK;
                drop    = 1'b1;
            end else begin
                hs_en   = 1'b1;
                hs_code = HS_ACK;
                commit  = 1'b1;
                tog_adv = 1'b1;
            end
        end
    end
endmodule

// File: rtl/out_ep_toggle.sv
// Module: out_ep_toggle
// Expected data toggle register. Clear has priority over advance.
module out_ep_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    output logic q
);
    // Toggle state update.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (adv) q <= ~q;
    end

    // R9: the toggle moves only on an advance or a clear.
    a_r9_toggle_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> $past(adv || clr));
endmodule

// File: rtl/out_ep_sticky.sv
// Module: out_ep_sticky
// One sticky flag: set by hardware, cleared by software, set wins.
module out_ep_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Sticky bit update.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R11: a flag rises only from a hardware set.
    a_r11_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(set));
    // R11: a lone clear empties the flag.
    a_r11_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
endmodule

// File: rtl/usb_out_ep_rx.sv
// Module: usb_out_ep_rx
// Receive handshake controller for one OUT endpoint. Arms on an OUT
// token, judges the following end-of-packet event and registers the
// verdict, flags, byte count and toggle one cycle later.
// Assumes at most one end-of-packet per token and single-cycle pulses.
module usb_out_ep_rx
    import usb_out_ep_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int MAX_PKT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_out,
    input  logic             pkt_end,
    input  logic             pkt_pid1,
    input  logic [CNT_W-1:0] pkt_len,
    input  logic             pkt_err,
    input  logic [CNT_W-1:0] fifo_free,
    input  logic             cfg_iso,
    input  logic             cfg_auto_clr,
    input  logic             sw_stall,
    input  logic             tog_clr,
    input  logic             rdy_clr,
    input  logic [2:0]       flag_clr,
    input  logic             rd_done,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             pkt_commit,
    output logic             pkt_drop,
    output logic             pkt_ready,
    output logic [CNT_W-1:0] rx_count,
    output logic             exp_toggle,
    output logic             fifo_full,
    output logic             overrun,
    output logic             data_err,
    output logic             sent_stall
);
    localparam logic [CNT_W-1:0] MAX_PKT_V = CNT_W'(MAX_PKT);

    logic              armed;
    logic              evt;
    logic              d_hs_en;
    hs_code_e          d_hs_code;
    hs_code_e          hs_q;
    logic              d_commit;
    logic              d_drop;
    logic [FLAG_N-1:0] d_flag_set;
    logic [FLAG_N-1:0] flag_q;
    logic              d_tog_adv;

    assign evt = pkt_end && armed;

    out_ep_decide #(.CNT_W(CNT_W)) u_decide (
        .evt      (evt),
        .pid1     (pkt_pid1),
        .len      (pkt_len),
        .free     (fifo_free),
        .crc_err  (pkt_err),
        .stall    (sw_stall),
        .iso      (cfg_iso),
        .tog_exp  (exp_toggle),
        .hs_en    (d_hs_en),
        .hs_code  (d_hs_code),
        .commit   (d_commit),
        .drop     (d_drop),
        .flag_set (d_flag_set),
        .tog_adv  (d_tog_adv)
    );

    out_ep_toggle u_toggle (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (d_tog_adv),
        .clr   (tog_clr),
        .q     (exp_toggle)
    );

    for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
        out_ep_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (d_flag_set[gi]),
            .clr   (flag_clr[gi]),
            .q     (flag_q[gi])
        );
    end

    // Token arming: set by a token, consumed by end-of-packet.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (tok_out)  armed <= 1'b1;
        else if (pkt_end)  armed <= 1'b0;
    end

    // Verdict strobes registered for the FIFO and the transmitter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid   <= 1'b0;
            hs_q       <= HS_NONE;
            pkt_commit <= 1'b0;
            pkt_drop   <= 1'b0;
        end else begin
            hs_valid   <= d_hs_en;
            hs_q       <= d_hs_code;
            pkt_commit <= d_commit;
            pkt_drop   <= d_drop;
        end
    end

    // Byte count of the last accepted packet.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_count <= '0;
        else if (d_commit) rx_count <= pkt_len;
    end

    // Packet-ready: commit sets, software or auto drain clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 pkt_ready <= 1'b0;
        else if (d_commit)                          pkt_ready <= 1'b1;
        else if (rdy_clr || (cfg_auto_clr && rd_done)) pkt_ready <= 1'b0;
    end

    assign hs_code    = hs_q;
    assign fifo_full  = fifo_free < MAX_PKT_V;
    assign overrun    = flag_q[FLAG_OVR];
    assign data_err   = flag_q[FLAG_ERR];
    assign sent_stall = flag_q[FLAG_STL];

    // R6: an errored packet is silent, not committed, and flagged.
    a_r6_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && pkt_err) |=> (!hs_valid && !pkt_commit && data_err));
    // R8: isochronous packets never get a handshake.
    a_r8_iso_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && cfg_iso) |=> !hs_valid);
    // R7: a STALL answer leaves the sent-stall flag set.
    a_r7_stall_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'b11) |-> sent_stall);
    // R3: a committed packet is visible as ready.
    a_r3_commit_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_commit |-> pkt_ready);
    // R4: commit and drop never coincide.
    a_r4_commit_drop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_commit && pkt_drop));
    // R2: strobes appear only after a counted event.
    a_r2_no_event_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> (!hs_valid && !pkt_commit && !pkt_drop));
endmodule

// File: tb/usb_out_ep_rx_bench.sv
`timescale 1ns/1ps
module usb_out_ep_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_out = 0, pkt_end = 0, pkt_pid1 = 0, pkt_err = 0;
    logic [9:0] pkt_len = 0, fifo_free = 10'd512;
    logic       cfg_iso = 0, cfg_auto_clr = 0, sw_stall = 0;
    logic       tog_clr = 0, rdy_clr = 0, rd_done = 0;
    logic [2:0] flag_clr = 0;
    logic       hs_valid, pkt_commit, pkt_drop, pkt_ready, exp_toggle;
    logic       fifo_full, overrun, data_err, sent_stall;
    logic [1:0] hs_code;
    logic [9:0] rx_count;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    usb_out_ep_rx u_usb_out_ep_rx (
        .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .pkt_end(pkt_end),
        .pkt_pid1(pkt_pid1), .pkt_len(pkt_len), .pkt_err(pkt_err),
        .fifo_free(fifo_free), .cfg_iso(cfg_iso), .cfg_auto_clr(cfg_auto_clr),
        .sw_stall(sw_stall), .tog_clr(tog_clr), .rdy_clr(rdy_clr),
        .flag_clr(flag_clr), .rd_done(rd_done), .hs_valid(hs_valid),
        .hs_code(hs_code), .pkt_commit(pkt_commit), .pkt_drop(pkt_drop),
        .pkt_ready(pkt_ready), .rx_count(rx_count), .exp_toggle(exp_toggle),
        .fifo_full(fifo_full), .overrun(overrun), .data_err(data_err),
        .sent_stall(sent_stall)
    );

    typedef struct packed {
        logic       pid;
        logic [9:0] len;
        logic       err;
        logic [9:0] free;
        logic       stall;
        logic       iso;
        logic       ehs;
        logic [1:0] ecode;
        logic       ecom;
        logic       edrop;
        logic       etog;
        logic [9:0] ecnt;
        logic [3:0] req;
    } vec_t;

    // pid len err free stall iso | hs code commit drop toggle count | req
    localparam vec_t VECS [12] = '{
        '{1'b0, 10'd8,  1'b0, 10'd512, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 10'd8,  4'd3}, // R3 accept
        '{1'b0, 10'd8,  1'b0, 10'd512, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 10'd8,  4'd4}, // R4 duplicate
        '{1'b1, 10'd16, 1'b0, 10'd512, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 10'd16, 4'd3}, // R3 DATA1
        '{1'b0, 10'd20, 1'b1, 10'd512, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 10'd16, 4'd6}, // R6 error
        '{1'b0, 10'd64, 1'b0, 10'd32,  1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 10'd16, 4'd5}, // R5 overrun
        '{1'b0, 10'd4,  1'b0, 10'd512, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 10'd16, 4'd7}, // R7 stall
        '{1'b0, 10'd10, 1'b0, 10'd512, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 10'd10, 4'd8}, // R8 iso
        '{1'b1, 10'd10, 1'b0, 10'd512, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 10'd10, 4'd8}, // R8 iso pid ignored
        '{1'b0, 10'd32, 1'b0, 10'd32,  1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 10'd32, 4'd5}, // R5 exact fit
        '{1'b1, 10'd0,  1'b0, 10'd512, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 10'd0,  4'd3}, // R3 zero length
        '{1'b0, 10'd3,  1'b1, 10'd512, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 10'd0,  4'd6}, // R6 over stall
        '{1'b1, 10'd5,  1'b0, 10'd512, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 10'd5,  4'd8}  // R8 stall ignored
    };

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Token in one cycle, packet end with fields in the next, sample after.
    task automatic send(input logic pid, input logic [9:0] len, input logic err,
                        input logic [9:0] free, input logic stall, input logic iso);
        @(negedge clk);
        tok_out = 1;
        @(negedge clk);
        tok_out = 0; pkt_end = 1; pkt_pid1 = pid; pkt_len = len;
        pkt_err = err; fifo_free = free; sw_stall = stall; cfg_iso = iso;
        @(negedge clk);
        pkt_end = 0;
    endtask

    task automatic defaults();
        pkt_err = 0; fifo_free = 10'd512; sw_stall = 0; cfg_iso = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state during reset
        check("R1 hs_valid", hs_valid, 0);
        check("R1 ready", pkt_ready, 0);
        check("R1 flags", {overrun, data_err, sent_stall}, 0);
        check("R1 toggle", exp_toggle, 0);
        check("R1 count", rx_count, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 strobes after reset", {hs_valid, pkt_commit, pkt_drop}, 0);

        // Vector table walk
        for (int i = 0; i < 12; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VECS[i].req, i);
            send(VECS[i].pid, VECS[i].len, VECS[i].err, VECS[i].free,
                 VECS[i].stall, VECS[i].iso);
            check({t, " hs_valid"}, hs_valid, VECS[i].ehs);
            check({t, " hs_code"}, hs_code, VECS[i].ecode);
            check({t, " commit"}, pkt_commit, VECS[i].ecom);
            check({t, " drop"}, pkt_drop, VECS[i].edrop);
            check({t, " toggle"}, exp_toggle, VECS[i].etog);
            check({t, " count"}, rx_count, VECS[i].ecnt);
            defaults();
        end

        // R5 R6 R7: sticky flags held after the table
        check("R5 overrun sticky", overrun, 1);
        check("R6 data_err sticky", data_err, 1);
        check("R7 sent_stall sticky", sent_stall, 1);

        // R11: individual clears
        @(negedge clk); flag_clr = 3'b001;
        @(negedge clk); flag_clr = 3'b000;
        check("R11 overrun cleared", overrun, 0);
        check("R11 data_err kept", data_err, 1);
        @(negedge clk); flag_clr = 3'b110;
        @(negedge clk); flag_clr = 3'b000;
        check("R11 err+stall cleared", {data_err, sent_stall}, 0);

        // R11: set wins over clear in the same cycle
        @(negedge clk); tok_out = 1;
        @(negedge clk); tok_out = 0; pkt_end = 1; pkt_pid1 = 0;
        pkt_len = 10'd40; fifo_free = 10'd8; flag_clr = 3'b001;
        @(negedge clk); pkt_end = 0; flag_clr = 0;
        check("R11 set wins", overrun, 1);
        check("R5 NAK code", hs_code, 2);
        defaults();

        // R12: full flag at the boundary
        fifo_free = 10'd63; #1;
        check("R12 full below max", fifo_full, 1);
        fifo_free = 10'd64; #1;
        check("R12 not full at max", fifo_full, 0);
        defaults();

        // R10: manual mode, drained ignored, software clear works
        @(negedge clk);
        check("R10 ready before", pkt_ready, 1);
        rd_done = 1;
        @(negedge clk); rd_done = 0;
        check("R10 drained ignored", pkt_ready, 1);
        rdy_clr = 1;
        @(negedge clk); rdy_clr = 0;
        check("R10 sw clear", pkt_ready, 0);

        // R10: auto-clear mode
        cfg_auto_clr = 1;
        send(1'b0, 10'd12, 1'b0, 10'd512, 1'b0, 1'b0);
        check("R10 ready set", pkt_ready, 1);
        check("R3 toggle advanced", exp_toggle, 1);
        rd_done = 1;
        @(negedge clk); rd_done = 0;
        check("R10 auto clear", pkt_ready, 0);
        cfg_auto_clr = 0;

        // R9: clear toggle
        tog_clr = 1;
        @(negedge clk); tog_clr = 0;
        check("R9 toggle cleared", exp_toggle, 0);

        // R9: clear wins over advance
        send(1'b0, 10'd7, 1'b0, 10'd512, 1'b0, 1'b0);
        check("R9 toggle at 1", exp_toggle, 1);
        @(negedge clk); tok_out = 1;
        @(negedge clk); tok_out = 0; pkt_end = 1; pkt_pid1 = 1;
        pkt_len = 10'd9; tog_clr = 1;
        @(negedge clk); pkt_end = 0; tog_clr = 0;
        check("R9 clear beats advance", exp_toggle, 0);
        check("R3 accepted with clear", pkt_commit, 1);
        check("R3 count 9", rx_count, 9);

        // R2: end of packet without a token
        @(negedge clk); pkt_end = 1; pkt_pid1 = 0; pkt_len = 10'd33;
        @(negedge clk); pkt_end = 0;
        check("R2 no handshake", hs_valid, 0);
        check("R2 no strobes", {pkt_commit, pkt_drop}, 0);
        check("R2 count kept", rx_count, 9);
        check("R2 toggle kept", exp_toggle, 0);

        // R6: toggle and ready unchanged by an errored packet
        send(1'b0, 10'd2, 1'b1, 10'd512, 1'b0, 1'b0);
        check("R6 ready unchanged", pkt_ready, 1);
        check("R6 toggle unchanged", exp_toggle, 0);
        defaults();

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule